// File: doc/BRIEF.md
# Board configuration register and address remapper

This block is a small control unit for a 16-bit microcontroller board. It sits on the board's byte-wide I/O bus and has two registers. The status register shows the live levels of the configuration DIP switches and cannot be written. The configuration register can be read and written. It drives the CPU mode pins, the flash bus width, the flash/RAM block swap and the address-or-I/O use of the upper address pins. It also holds a mirror control that folds the low window 0x004000–0x00FFFF into the top 64 KiB bank.

The block also takes the 24-bit CPU address and produces a remapped address. From that remapped address it drives one-hot, active-low chip selects for the flash and the RAM. Bit 23 of the remapped address splits the upper memory block from the lower one.

A two-state controller sequences the register. `ST_LOAD` is entered on reset. In `ST_LOAD` the chip selects are held off and bus writes are ignored. On the first clock after reset is released, the controller takes the transition `LOAD_DONE`: it copies the switch fields into the register and moves to `ST_RUN`. In `ST_RUN` the controller takes the transition `CFG_WRITE` on a bus write to the configuration address. Otherwise it takes `RUN_HOLD`, which keeps the register value.

Top module: `board_cfg_ctrl`

## Requirements
- R1: After reset is released, the first clock edge loads the configuration register with the switch fields, and the register then reads as {1'b0, sw_i[6], sw_i[5], 1'b0, 1'b0, sw_i[2:0]}. The mirror bit (bit 7) and the address/IO bit (bit 4) come out of reset at 0.
- R2: A read (io_rd=1) of I/O address 0xC0 returns the present value of sw_i, with no register delay. A write to 0xC0 leaves the configuration register unchanged.
- R3: A write (io_wr=1) to I/O address 0xC1 in the run state updates the configuration register at the next clock edge. The register layout is: bit7 mirror, bit6 flash width, bit5 swap, bit4 address/IO, bit3 reserved, bits2:0 mode. A read of 0xC1 returns the register, with bit 3 always read as 0.
- R4: mode_o equals register bits 2:0. flash_wide_o equals bit 6, where 1 selects 16-bit flash access and 0 selects 8-bit. addr_io_o equals bit 4, where 1 lets A16–A23 be used as general I/O.
- R5: When bit 7 is 1 and cpu_addr_i lies in 0x004000–0x00FFFF, mem_addr_o is {8'hFF, cpu_addr_i[15:0]}. In every other case mem_addr_o equals cpu_addr_i.
- R6: During a memory cycle (mem_req_i=1) the outputs follow the swap bit (bit 5) and remapped address bit 23. With swap=0, bit23=1 selects flash (flash_cs_n=0) and bit23=0 selects RAM (ram_cs_n=0). With swap=1 this mapping is reversed. No more than one chip select is low at any time.
- R7: Both chip selects stay high in three cases: when mem_req_i=0, while the controller is in the load state, and during an I/O cycle (io_rd or io_wr) to 0xC0 or 0xC1.
- R8: A read of any other I/O address returns 0. A write to any other I/O address leaves the configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; enters the load state |
| sw_i | input | 8 | Configuration switch levels |
| io_addr | input | 8 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_req_i | input | 1 | Memory cycle in progress |
| cpu_addr_i | input | 24 | CPU address |
| mem_addr_o | output | 24 | Remapped memory address |
| flash_cs_n | output | 1 | Flash chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| mode_o | output | 3 | CPU mode pins |
| flash_wide_o | output | 1 | Flash bus width, 1 = 16-bit |
| addr_io_o | output | 1 | Upper address pins released for I/O |

## Verification
On every cycle, the assertions check the following:
- the two chip selects are never low together;
- both chip selects are idle during I/O cycles to the two register addresses;
- the status read follows the switches;
- bit 3 reads back as 0;
- addresses outside bank zero pass through unchanged;
- the mode pins take the written value one edge after a write and hold steady otherwise.

Only the bench scenarios can show the rest:
- the exact remapped address and the chip that is selected for each combination of mirror and swap;
- the window edges at 0x003FFF, 0x004000 and 0x00FFFF;
- the switch fields copied at reset and the mirror bit being cleared by a second reset;
- writes to the status address or to unused addresses having no effect.

// File: rtl/board_cfg_pkg.sv
package board_cfg_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic       mirror;
        logic       wide;
        logic       swap;
        logic       addr_io;
        logic       rsvd;
        logic [2:0] mode;
    } cfg_reg_t;

    localparam int unsigned CFG_W = $bits(cfg_reg_t);
endpackage

// File: rtl/board_cfg_regs.sv
module board_cfg_regs
    import board_cfg_pkg::*;
#(
    parameter int unsigned IO_AW    = 8,
    parameter logic [IO_AW-1:0] CFG_ADDR = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  sw_i,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic [CFG_W-1:0]  io_wdata,
    output cfg_reg_t          cfg_q,
    output logic              ready_o
);
    cfg_state_e state_q, state_d;
    cfg_reg_t   cfg_d;
    cfg_reg_t   sw_cfg, wr_cfg;
    logic       cfg_hit;

    assign cfg_hit = io_wr && (io_addr == CFG_ADDR);

    always_comb begin
        sw_cfg        = '0;
        sw_cfg.wide   = sw_i[6];
        sw_cfg.swap   = sw_i[5];
        sw_cfg.mode   = sw_i[2:0];
        wr_cfg        = cfg_reg_t'(io_wdata);
        wr_cfg.rsvd   = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    // Next state and register value
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_LOAD: begin
                cfg_d   = sw_cfg;          // LOAD_DONE
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cfg_hit) begin
                    cfg_d = wr_cfg;        // CFG_WRITE
                end                        // else RUN_HOLD
            end
            default: state_d = ST_LOAD;
        endcase
    end

    assign ready_o = (state_q == ST_RUN);
endmodule

// File: rtl/board_addr_remap.sv
module board_addr_remap #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned BANK_W  = 8,
    parameter int unsigned WIN_LO  = 16'h4000
) (
    input  logic              mirror_i,
    input  logic              swap_i,
    input  logic              sel_en_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              flash_cs_n,
    output logic              ram_cs_n
);
    localparam int unsigned OFS_W = ADDR_W - BANK_W;

    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
    logic              in_win;
    logic              upper;

    assign bank   = cpu_addr_i[ADDR_W-1 -: BANK_W];
    assign ofs    = cpu_addr_i[OFS_W-1:0];
    assign in_win = (bank == '0) && (ofs >= OFS_W'(WIN_LO));

    assign mem_addr_o = (mirror_i && in_win) ? {{BANK_W{1'b1}}, ofs} : cpu_addr_i;
    assign upper      = mem_addr_o[ADDR_W-1];

    assign flash_cs_n = !(sel_en_i && (upper ^ swap_i));
    assign ram_cs_n   = !(sel_en_i && !(upper ^ swap_i));
endmodule

// File: rtl/board_cfg_ctrl.sv
module board_cfg_ctrl
    import board_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned IO_AW  = 8,
    parameter logic [IO_AW-1:0] STAT_ADDR = 8'hC0,
    parameter logic [IO_AW-1:0] CFG_ADDR  = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sw_i,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              mem_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              flash_cs_n,
    output logic              ram_cs_n,
    output logic [2:0]        mode_o,
    output logic              flash_wide_o,
    output logic              addr_io_o
);
    cfg_reg_t cfg_q;
    logic     cfg_ready;
    logic     reg_cycle;

    board_cfg_regs #(.IO_AW(IO_AW), .CFG_ADDR(CFG_ADDR)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_i     (sw_i),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .cfg_q    (cfg_q),
        .ready_o  (cfg_ready)
    );

    assign reg_cycle = (io_rd || io_wr) &&
                       ((io_addr == STAT_ADDR) || (io_addr == CFG_ADDR));

    board_addr_remap #(.ADDR_W(ADDR_W)) remap_i (
        .mirror_i   (cfg_q.mirror),
        .swap_i     (cfg_q.swap),
        .sel_en_i   (mem_req_i && cfg_ready && !reg_cycle),
        .cpu_addr_i (cpu_addr_i),
        .mem_addr_o (mem_addr_o),
        .flash_cs_n (flash_cs_n),
        .ram_cs_n   (ram_cs_n)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == STAT_ADDR)     io_rdata = sw_i;
            else if (io_addr == CFG_ADDR) io_rdata = cfg_q;
        end
    end

    assign mode_o       = cfg_q.mode;
    assign flash_wide_o = cfg_q.wide;
    assign addr_io_o    = cfg_q.addr_io;
endmodule

// File: rtl/board_cfg_ctrl_chk.sv
module board_cfg_ctrl_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned IO_AW  = 8,
    parameter logic [IO_AW-1:0] STAT_ADDR = 8'hC0,
    parameter logic [IO_AW-1:0] CFG_ADDR  = 8'hC1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        sw_i,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              flash_cs_n,
    input logic              ram_cs_n,
    input logic [2:0]        mode_o,
    input logic              cfg_ready
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_cs_n && !ram_cs_n)); // R6

    AST_REG_CYCLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && (io_addr == STAT_ADDR || io_addr == CFG_ADDR))
        |-> (flash_cs_n && ram_cs_n)); // R7

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == STAT_ADDR) |-> (io_rdata == sw_i)); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == CFG_ADDR) |-> (io_rdata[3] == 1'b0)); // R3

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_i[ADDR_W-1 -: 8] != 8'h00) |-> (mem_addr_o == cpu_addr_i)); // R5

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && io_wr && io_addr == CFG_ADDR) |=> (mode_o == $past(io_wdata[2:0]))); // R4

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ready && !(io_wr && io_addr == CFG_ADDR)) |=> $stable(mode_o)); // R8
endmodule

bind board_cfg_ctrl board_cfg_ctrl_chk #(
    .ADDR_W(ADDR_W), .IO_AW(IO_AW), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_i       (sw_i),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cpu_addr_i (cpu_addr_i),
    .mem_addr_o (mem_addr_o),
    .flash_cs_n (flash_cs_n),
    .ram_cs_n   (ram_cs_n),
    .mode_o     (mode_o),
    .cfg_ready  (cfg_ready)
);

// File: tb/board_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module board_cfg_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sw_i = 8'h00;
    logic [7:0]  io_addr = 8'h00;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        mem_req_i = 1'b0;
    logic [23:0] cpu_addr_i = 24'h0;
    logic [23:0] mem_addr_o;
    logic        flash_cs_n, ram_cs_n;
    logic [2:0]  mode_o;
    logic        flash_wide_o, addr_io_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    board_cfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sw_i(sw_i), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_req_i(mem_req_i), .cpu_addr_i(cpu_addr_i), .mem_addr_o(mem_addr_o),
        .flash_cs_n(flash_cs_n), .ram_cs_n(ram_cs_n), .mode_o(mode_o),
        .flash_wide_o(flash_wide_o), .addr_io_o(addr_io_o)
    );

    // {cfg write, cpu addr, expected addr, exp flash_cs_n, exp ram_cs_n}
    localparam int NV = 9;
    localparam logic [57:0] VEC [NV] = '{
        {8'h00, 24'h804000, 24'h804000, 1'b0, 1'b1},
        {8'h00, 24'h004000, 24'h004000, 1'b1, 1'b0},
        {8'h80, 24'h004000, 24'hFF4000, 1'b0, 1'b1},
        {8'h80, 24'h00FFFF, 24'hFFFFFF, 1'b0, 1'b1},
        {8'h80, 24'h003FFF, 24'h003FFF, 1'b1, 1'b0},
        {8'h80, 24'h014000, 24'h014000, 1'b1, 1'b0},
        {8'hA0, 24'h008000, 24'hFF8000, 1'b1, 1'b0},
        {8'h20, 24'hC00000, 24'hC00000, 1'b1, 1'b0},
        {8'h20, 24'h000100, 24'h000100, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] sw);
        @(negedge clk);
        sw_i = sw; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);  // LOAD_DONE edge has passed
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        // R7: chip selects idle while in reset/load
        mem_req_i = 1'b1; cpu_addr_i = 24'h800000;
        @(negedge clk);
        check("R7 load cs", {30'd0, flash_cs_n, ram_cs_n}, 32'h3);
        mem_req_i = 1'b0;

        // R1: switch copy at reset
        do_reset(8'h5D);
        io_read(8'hC1, rd);
        check("R1 reset load", rd, 8'h45);
        check("R4 mode pins", mode_o, 3'd5);
        check("R4 flash width", flash_wide_o, 1'b1);
        check("R4 addr io", addr_io_o, 1'b0);

        // R2: status is live, writes ignored
        io_read(8'hC0, rd);
        check("R2 status", rd, 8'h5D);
        sw_i = 8'hA2;
        io_read(8'hC0, rd);
        check("R2 status live", rd, 8'hA2);
        io_write(8'hC0, 8'hFF);
        io_read(8'hC1, rd);
        check("R2 status write ignored", rd, 8'h45);

        // R8: other addresses
        io_write(8'h10, 8'hFF);
        io_read(8'hC1, rd);
        check("R8 stray write ignored", rd, 8'h45);
        io_read(8'h10, rd);
        check("R8 stray read zero", rd, 8'h00);

        // R3: readback with reserved bit
        io_write(8'hC1, 8'hFF);
        io_read(8'hC1, rd);
        check("R3 readback", rd, 8'hF7);
        check("R4 addr io set", addr_io_o, 1'b1);
        check("R4 mode set", mode_o, 3'd7);

        // R5/R6 vector walk
        for (int i = 0; i < NV; i++) begin
            io_write(8'hC1, VEC[i][57:50]);
            @(negedge clk);
            mem_req_i = 1'b1; cpu_addr_i = VEC[i][49:26];
            #1;
            check("R5 remap", mem_addr_o, VEC[i][25:2]);
            check("R6 chip select", {30'd0, flash_cs_n, ram_cs_n}, {30'd0, VEC[i][1:0]});
            mem_req_i = 1'b0;
        end

        // R7: no request, and register cycle
        @(negedge clk);
        cpu_addr_i = 24'h800000; mem_req_i = 1'b0;
        #1 check("R7 no req", {30'd0, flash_cs_n, ram_cs_n}, 32'h3);
        mem_req_i = 1'b1; io_addr = 8'hC0; io_rd = 1'b1;
        #1 check("R7 reg cycle", {30'd0, flash_cs_n, ram_cs_n}, 32'h3);
        io_rd = 1'b0; mem_req_i = 1'b0;

        // R1: second reset clears mirror, recopies switches
        io_write(8'hC1, 8'h80);
        do_reset(8'h22);
        io_read(8'hC1, rd);
        check("R1 second reset", rd, 8'h22);
        @(negedge clk);
        mem_req_i = 1'b1; cpu_addr_i = 24'h004000;
        #1 check("R1 mirror cleared", mem_addr_o, 24'h004000);
        mem_req_i = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule